// File: doc/BRIEF.md
# Addressed Serial Loader for an Eight-Channel Converter Register Bank

This block is the digital front end of an eight-channel, 12-bit converter. A host sends 16-bit words on a serial line, framed by an active-low frame-sync input and clocked by a serial clock. The bits are captured on the serial clock's falling edge. Each word carries a 12-bit code, one device-address bit and a three-bit channel number. When the address bit equals the level on a strap input, the code is written into the input register of the chosen channel. The words are also passed on, unchanged, through a serial output so that several devices can be chained.

Behind the eight input registers is a second bank of eight output registers, and the eight output codes leave the block on a parallel bus. A low level on the load input copies every input register into its output register at the same moment. A low level on the clear input forces every output register to zero. Clear wins when both are low, and clear leaves the input registers untouched.

Everything runs on one fast system clock. The serial clock, frame sync, serial data, load and clear are first passed through two-flop synchronizers. Falling edges of the serial clock are then found by comparing successive samples. This only works when the system clock runs at least four times as fast as the serial clock.

Top module: `dac_serial_loader`

## Requirements
- R1: Serial bits are taken only on serial clock falling edges that occur while frame sync is low; clock edges while frame sync is high shift nothing and are not counted.
- R2: A word is 16 bits sent most significant bit first; word bits 15..4 are the 12-bit code, bit 3 is the address bit, bits 2..0 are the channel number.
- R3: Channel number value k (0..7) selects channel k, whose output code appears on `dac_out[12*k+11 : 12*k]`.
- R4: The code is written into the selected input register on the sixteenth falling edge after frame sync goes low, provided the address bit equals `addr_strap`; edges after the sixteenth in the same frame write nothing.
- R5: When the address bit differs from `addr_strap`, no input register changes.
- R6: The bit count restarts whenever frame sync is high, so a frame with fewer than sixteen falling edges writes nothing.
- R7: `sdo` presents the bit that was shifted in sixteen falling edges earlier and updates after each falling edge, whether or not the address matched.
- R8: While `load_n` is low (and `clear_n` high), every output register takes the value of its input register.
- R9: While `clear_n` is low, every output register is zero, even if `load_n` is also low.
- R10: After reset, all input and output registers and `sdo` are zero.
- R11: Clear does not alter the input registers; a load after a clear restores the codes written before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; bits are taken on its falling edge |
| fs_n | input | 1 | Active-low frame sync |
| sdi | input | 1 | Serial data in, most significant bit first |
| addr_strap | input | 1 | Device address level, held static |
| load_n | input | 1 | Active-low load: copy input registers to output registers |
| clear_n | input | 1 | Active-low clear of the output registers |
| sdo | output | 1 | Serial data out for chaining |
| dac_out | output | 96 | Eight 12-bit output codes, channel 0 in the low bits |

## Verification
The assertions assume that the serial clock, frame sync, data, load and clear change slowly compared with the system clock. Each level must last at least two system cycles, so that every falling edge is seen exactly once. They also assume that `sdi` is stable around the falling edge, and that `addr_strap` does not move while a frame is in progress. The stimulus keeps every serial clock phase four system cycles long. It changes data and frame sync only while the serial clock is high, holds each strobe for four cycles, and changes the strap only between frames.

// File: rtl/dacl_pkg.sv
`timescale 1ns/1ps
package dacl_pkg;
    // Positions of the individual lines inside the synchronizer vector
    typedef enum int unsigned {
        SY_SCLK = 0,
        SY_FS   = 1,
        SY_SDI  = 2,
        SY_LD   = 3,
        SY_CLR  = 4
    } sync_idx_e;
    localparam int unsigned SYNC_LINES = 5;
    // Idle levels: clock, frame sync and both strobes rest high, data rests low
    localparam logic [SYNC_LINES-1:0] SYNC_IDLE = 5'b11011;
endpackage

// File: rtl/dacl_sync.sv
`timescale 1ns/1ps
module dacl_sync #(
    parameter int unsigned W      = 5,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] IDLE  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{IDLE}};
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/dacl_shift.sv
`timescale 1ns/1ps
module dacl_shift #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned CODE_W = 12,
    parameter int unsigned SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              fs_n_s,
    input  logic              sdi_s,
    input  logic              addr_strap,
    output logic              sdo,
    output logic              wr_en,
    output logic [SEL_W-1:0]  wr_sel,
    output logic [CODE_W-1:0] wr_code
);
    localparam int unsigned CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              sclk_prev;
        logic              wr_en;
        logic [SEL_W-1:0]  wr_sel;
        logic [CODE_W-1:0] wr_code;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic              fall;
    logic [WORD_W-1:0] word_nx;

    always_comb begin
        st_d           = st_q;
        st_d.wr_en     = 1'b0;
        st_d.sclk_prev = sclk_s;
        fall           = st_q.sclk_prev & ~sclk_s;
        word_nx        = {st_q.shreg[WORD_W-2:0], sdi_s};
        if (fs_n_s) begin
            st_d.cnt = '0;
        end else if (fall) begin
            st_d.shreg = word_nx;
            if (st_q.cnt != CNT_FULL) st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_LAST && word_nx[SEL_W] == addr_strap) begin
                st_d.wr_en   = 1'b1;
                st_d.wr_sel  = word_nx[SEL_W-1:0];
                st_d.wr_code = word_nx[WORD_W-1 -: CODE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo     = st_q.shreg[WORD_W-1];
    assign wr_en   = st_q.wr_en;
    assign wr_sel  = st_q.wr_sel;
    assign wr_code = st_q.wr_code;

    // R1: with frame sync high nothing is shifted
    assert_idle_no_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fs_n_s |=> $stable(st_q.shreg));
    // R6: the bit count is back at zero after frame sync is seen high
    assert_count_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fs_n_s |=> (st_q.cnt == '0));
    // R4: a write is issued only together with the sixteenth counted edge
    assert_write_on_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (st_q.cnt == CNT_FULL && $past(st_q.cnt) == CNT_LAST));
endmodule

// File: rtl/dacl_bank.sv
`timescale 1ns/1ps
module dacl_bank #(
    parameter int unsigned CHANNELS = 8,
    parameter int unsigned CODE_W   = 12,
    parameter int unsigned SEL_W    = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [SEL_W-1:0]             wr_sel,
    input  logic [CODE_W-1:0]            wr_code,
    input  logic                         load_act,
    input  logic                         clear_act,
    output logic [CHANNELS*CODE_W-1:0]   out_flat
);
    typedef struct packed {
        logic [CHANNELS-1:0][CODE_W-1:0] inl;
        logic [CHANNELS-1:0][CODE_W-1:0] outl;
    } bank_st_t;

    bank_st_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        if (wr_en && int'(wr_sel) < CHANNELS) bk_d.inl[wr_sel] = wr_code;
        if (clear_act)     bk_d.outl = '0;
        else if (load_act) bk_d.outl = bk_q.inl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign out_flat = bk_q.outl;

    // R9: clear forces all outputs to zero, whatever load does
    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_act |=> (out_flat == '0));
    // R8: load copies the whole input bank at once
    assert_load_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_act && !clear_act) |=> (bk_q.outl == $past(bk_q.inl)));
    // R5, R11: input registers move only on a write strobe
    assert_inputs_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bk_q.inl));
endmodule

// File: rtl/dac_serial_loader.sv
`timescale 1ns/1ps
module dac_serial_loader #(
    parameter int unsigned CHANNELS = 8,
    parameter int unsigned CODE_W   = 12,
    parameter int unsigned WORD_W   = 16,
    parameter int unsigned STAGES   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sclk,
    input  logic                       fs_n,
    input  logic                       sdi,
    input  logic                       addr_strap,
    input  logic                       load_n,
    input  logic                       clear_n,
    output logic                       sdo,
    output logic [CHANNELS*CODE_W-1:0] dac_out
);
    import dacl_pkg::*;
    localparam int unsigned SEL_W = $clog2(CHANNELS);

    logic [SYNC_LINES-1:0] raw, syn;
    logic                  wr_en;
    logic [SEL_W-1:0]      wr_sel;
    logic [CODE_W-1:0]     wr_code;

    always_comb begin
        raw          = '0;
        raw[SY_SCLK] = sclk;
        raw[SY_FS]   = fs_n;
        raw[SY_SDI]  = sdi;
        raw[SY_LD]   = load_n;
        raw[SY_CLR]  = clear_n;
    end

    dacl_sync #(.W(SYNC_LINES), .STAGES(STAGES), .IDLE(SYNC_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw), .sync_o(syn)
    );

    dacl_shift #(.WORD_W(WORD_W), .CODE_W(CODE_W), .SEL_W(SEL_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .sclk_s(syn[SY_SCLK]), .fs_n_s(syn[SY_FS]), .sdi_s(syn[SY_SDI]),
        .addr_strap(addr_strap), .sdo(sdo),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_code(wr_code)
    );

    dacl_bank #(.CHANNELS(CHANNELS), .CODE_W(CODE_W), .SEL_W(SEL_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_code(wr_code),
        .load_act(~syn[SY_LD]), .clear_act(~syn[SY_CLR]),
        .out_flat(dac_out)
    );
endmodule

// File: tb/tb_dac_serial_loader.sv
`timescale 1ns/1ps
module tb_dac_serial_loader;
    localparam int CH = 8;
    localparam int CW = 12;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1, fs_n = 1'b1, sdi = 1'b0, addr_strap = 1'b1;
    logic load_n = 1'b1, clear_n = 1'b1;
    logic sdo;
    logic [CH*CW-1:0] dac_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    logic [CW-1:0] exp_in  [CH];
    logic [CW-1:0] exp_out [CH];

    typedef struct {
        int              due;
        int              req;
        logic [CH*CW-1:0] val;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dac_serial_loader dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .fs_n(fs_n), .sdi(sdi),
        .addr_strap(addr_strap), .load_n(load_n), .clear_n(clear_n),
        .sdo(sdo), .dac_out(dac_out)
    );

    task automatic chk(input int req, input logic [CH*CW-1:0] act, input logic [CH*CW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [CH*CW-1:0] pack_out();
        logic [CH*CW-1:0] v;
        for (int c = 0; c < CH; c++) v[c*CW +: CW] = exp_out[c];
        return v;
    endfunction

    // Scoreboard push: expected output bus, compared by the monitor
    task automatic expect_out(input int req);
        item_t it;
        it.due = cyc;
        it.req = req;
        it.val = pack_out();
        sb_q.push_back(it);
        repeat (2) @(posedge clk);
    endtask

    // Monitor: pops items that are due and compares them with the bus
    always @(negedge clk) begin
        if (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            item_t it;
            it = sb_q.pop_front();
            chk(it.req, dac_out, it.val);
        end
    end

    // Sends n bits (fb[n-1] first) in one frame; updates the model; checks sdo (R7)
    task automatic send_frame(input logic [31:0] fb, input int n);
        logic [15:0] w;
        fs_n = 1'b0;
        repeat (HALF) @(posedge clk);
        for (int i = 0; i < n; i++) begin
            sdi  = fb[n-1-i];
            sclk = 1'b1;
            repeat (HALF) @(posedge clk);
            if (i >= 16) begin
                @(negedge clk);
                chk(7, {{(CH*CW-1){1'b0}}, sdo}, {{(CH*CW-1){1'b0}}, fb[n-1-(i-16)]});
            end
            sclk = 1'b0;
            repeat (HALF) @(posedge clk);
        end
        sclk = 1'b1;
        repeat (HALF) @(posedge clk);
        fs_n = 1'b1;
        repeat (2*HALF) @(posedge clk);
        if (n >= 16) begin
            w = fb[n-1 -: 16];
            if (w[3] == addr_strap) exp_in[w[2:0]] = w[15:4];
        end
    endtask

    task automatic pulse(input bit ld, input bit cl);
        load_n  = ~ld;
        clear_n = ~cl;
        repeat (HALF) @(posedge clk);
        load_n  = 1'b1;
        clear_n = 1'b1;
        repeat (HALF) @(posedge clk);
        if (cl)      for (int c = 0; c < CH; c++) exp_out[c] = '0;
        else if (ld) for (int c = 0; c < CH; c++) exp_out[c] = exp_in[c];
    endtask

    function automatic logic [15:0] mk(input logic [11:0] code, input logic a, input logic [2:0] s);
        return {code, a, s};
    endfunction

    initial begin
        for (int c = 0; c < CH; c++) begin exp_in[c] = '0; exp_out[c] = '0; end
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        // R10: reset state of outputs and sdo
        expect_out(10);
        @(negedge clk);
        chk(10, {{(CH*CW-1){1'b0}}, sdo}, '0);

        // R2, R3, R4, R8: one matching word per channel, then load
        for (int c = 0; c < CH; c++) begin
            send_frame({16'h0, mk(12'h100 + 12'h111 * c[11:0], 1'b1, c[2:0])}, 16);
        end
        pulse(1, 0);
        expect_out(8);

        // R5: address mismatch leaves channel 2 alone
        send_frame({16'h0, mk(12'hABC, 1'b0, 3'd2)}, 16);
        pulse(1, 0);
        expect_out(5);

        // R6: short frame of 10 bits writes nothing
        send_frame({22'h0, 10'h3FF}, 10);
        pulse(1, 0);
        expect_out(6);

        // R1: clock activity with frame sync high is ignored, then a clean word
        for (int i = 0; i < 5; i++) begin
            sdi = 1'b1; sclk = 1'b0; repeat (HALF) @(posedge clk);
            sclk = 1'b1; repeat (HALF) @(posedge clk);
        end
        send_frame({16'h0, mk(12'h5A5, 1'b1, 3'd5)}, 16);
        pulse(1, 0);
        expect_out(1);

        // R9: clear zeroes outputs
        pulse(0, 1);
        expect_out(9);
        // R11: load after clear brings the input registers back
        pulse(1, 0);
        expect_out(11);
        // R9: clear and load together -> clear wins
        pulse(1, 1);
        expect_out(9);

        // R7, R4: 32-bit frame, first word mismatched, second not written
        send_frame({mk(12'hC3C, 1'b0, 3'd7), mk(12'h0F0, 1'b1, 3'd1)}, 32);
        pulse(1, 0);
        expect_out(4);

        // R7: forwarding of a matching word followed by a pattern
        send_frame({mk(12'h9A6, 1'b1, 3'd3), 16'hA55A}, 32);
        pulse(1, 0);
        expect_out(7);

        // R4: strap low accepts an address bit of 0 and rejects 1
        addr_strap = 1'b0;
        repeat (4) @(posedge clk);
        send_frame({16'h0, mk(12'h321, 1'b0, 3'd0)}, 16);
        send_frame({16'h0, mk(12'h777, 1'b1, 3'd6)}, 16);
        pulse(1, 0);
        expect_out(4);

        // R3: highest channel number hits the top slice
        send_frame({16'h0, mk(12'hFFF, 1'b0, 3'd7)}, 16);
        pulse(1, 0);
        expect_out(3);

        repeat (10) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule